// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Register

This block is the status and control word that sits beside a floating-point unit. It holds four fields: cause bits, which record the exceptions raised by the most recent operation; sticky flag bits, which accumulate every exception raised since software last wrote them; trap enable bits; and a two-bit rounding-mode selector that drives the arithmetic datapath.

The processor reads and writes the word through a simple single-cycle port. The floating-point unit pulses `opStart` when an operation begins, which wipes the cause field. At the end of the operation it presents a vector of exception events. Any raised cause that has its enable bit set requests a trap. The error cause has no enable bit and no flag bit, so it always requests a trap.

Top module: `fpExcStatusReg`

## Requirements
- R1: After reset every bit of `regRdData` is 0, `roundMode` is 00 (round to nearest) and `trapReq` is 0.
- R2: Bits 31 to 18 of `regRdData` always read 0, and writing ones to them has no effect.
- R3: A write with `regWrEn` high loads cause (bits 17:12, E,V,Z,O,U,I from high to low), enable (bits 11:7, V,Z,O,U,I), flag (bits 6:2, V,Z,O,U,I) and rounding mode (bits 1:0). The new value is readable on the next cycle.
- R4: `opStart` clears all six cause bits on the next cycle. Enable, flag and rounding-mode bits keep their values.
- R5: With `excValid` high, each set bit of `excVec` sets the matching cause bit, and for V..I also the matching flag bit. The encoding is bit 5=E, 4=V, 3=Z, 2=O, 1=U, 0=I. The E event sets no flag bit. Bits that are already set stay set.
- R6: Flag bits stay set across later `opStart` pulses and later events until a register write changes them.
- R7: `trapReq` is high exactly while some cause bit among V..I is set together with its enable bit, or while cause E is set.
- R8: Cause E raises `trapReq` whatever the enable field holds.
- R9: When a write and an exception event fall in the same cycle, the event's cause and flag bits are ORed over the written value.
- R10: When `opStart` and an exception event fall in the same cycle, the cause field holds exactly the event's bits on the next cycle.
- R11: `roundMode` equals bits 1:0 of the register. The reserved codes 10 and 11 are stored and output as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe from the processor |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Current register contents |
| opStart | input | 1 | Start of a floating-point operation |
| excValid | input | 1 | Exception vector is valid this cycle |
| excVec | input | 6 | Raised exceptions, bit 5=E down to bit 0=I |
| roundMode | output | 2 | Rounding mode to the datapath |
| trapReq | output | 1 | Trap request |

## Verification
The bench aims at the collisions: a write meeting an event, where a design that lets the write win would lose a flag, and an operation start meeting an event, where a design that clears last would drop the new cause. It checks that flags survive operation starts, where a design that cleared both fields would forget history. It raises E with every enable cleared, because a design that gates E by an enable bit would never trap. It also writes ones to the reserved bits and sets the reserved rounding codes, where a leaky design would read back stray bits.

// File: rtl/fpExcPkg.sv
package fpExcPkg;
  localparam int REG_W     = 32;
  localparam int NUM_EXC   = 6;          // E,V,Z,O,U,I
  localparam int NUM_MASK  = NUM_EXC - 1; // V..I only
  localparam int RM_W      = 2;
  localparam int RM_LSB    = 0;
  localparam int FLAG_LSB  = RM_LSB + RM_W;        // 2
  localparam int EN_LSB    = FLAG_LSB + NUM_MASK;  // 7
  localparam int CAUSE_LSB = EN_LSB + NUM_MASK;    // 12
  localparam int USED_W    = CAUSE_LSB + NUM_EXC;  // 18
  localparam int ERR_IDX   = NUM_EXC - 1;          // E is top bit of cause

  typedef struct packed {
    logic loadAll;   // processor write
    logic clrCause;  // operation start
    logic setEvt;    // exception event
  } fpStrobeT;
endpackage

// File: rtl/fpExcControl.sv
module fpExcControl
  import fpExcPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                opStart,
  input  logic                excValid,
  input  logic [NUM_EXC-1:0]  excVec,
  input  logic [NUM_EXC-1:0]  causeQ,
  input  logic [NUM_MASK-1:0] enableQ,
  output fpStrobeT            strobes,
  output logic                trapReq
);
  logic [NUM_MASK-1:0] hitVec;

  always_comb begin
    strobes.loadAll  = regWrEn;
    strobes.clrCause = opStart;
    strobes.setEvt   = excValid;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_MASK; gi++) begin : gHit
      assign hitVec[gi] = causeQ[gi] & enableQ[gi];
    end
  endgenerate

  assign trapReq = causeQ[ERR_IDX] | (|hitVec);

  // E event always traps on the following cycle
  assert_err_traps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excVec[ERR_IDX]) |=> trapReq);

  // an enabled event that no write disturbs must trap
  assert_enabled_traps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && !regWrEn && ((excVec[NUM_MASK-1:0] & enableQ) != '0)) |=> trapReq);

  // no cause bits, no trap
  assert_quiet_no_trap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (causeQ == '0) |-> !trapReq);
endmodule

// File: rtl/fpExcDatapath.sv
module fpExcDatapath
  import fpExcPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  fpStrobeT            strobes,
  input  logic [USED_W-1:0]   wrFields,
  input  logic [NUM_EXC-1:0]  excVec,
  output logic [NUM_EXC-1:0]  causeQ,
  output logic [NUM_MASK-1:0] enableQ,
  output logic [NUM_MASK-1:0] flagQ,
  output logic [RM_W-1:0]     rmQ
);
  logic [NUM_EXC-1:0]  causeD;
  logic [NUM_MASK-1:0] flagD;
  logic [NUM_MASK-1:0] enableD;
  logic [RM_W-1:0]     rmD;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_EXC; gi++) begin : gCause
      logic baseBit;
      always_comb begin
        if (strobes.clrCause)     baseBit = 1'b0;
        else if (strobes.loadAll) baseBit = wrFields[CAUSE_LSB+gi];
        else                      baseBit = causeQ[gi];
        causeD[gi] = baseBit | (strobes.setEvt & excVec[gi]);
      end
    end
    for (gi = 0; gi < NUM_MASK; gi++) begin : gFlag
      logic baseBit;
      always_comb begin
        baseBit    = strobes.loadAll ? wrFields[FLAG_LSB+gi] : flagQ[gi];
        flagD[gi]  = baseBit | (strobes.setEvt & excVec[gi]);
      end
    end
  endgenerate

  always_comb begin
    enableD = strobes.loadAll ? wrFields[EN_LSB +: NUM_MASK] : enableQ;
    rmD     = strobes.loadAll ? wrFields[RM_LSB +: RM_W]     : rmQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ  <= '0;
      flagQ   <= '0;
      enableQ <= '0;
      rmQ     <= '0;
    end else begin
      causeQ  <= causeD;
      flagQ   <= flagD;
      enableQ <= enableD;
      rmQ     <= rmD;
    end
  end

  // flags never drop without a write
  assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadAll |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  // an event raises its cause and flag bits, even against a write
  assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setEvt |=> (((causeQ & $past(excVec)) == $past(excVec)) &&
                        ((flagQ & $past(excVec[NUM_MASK-1:0])) == $past(excVec[NUM_MASK-1:0]))));

  // operation start without event leaves no cause
  assert_cause_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrCause && !strobes.setEvt) |=> (causeQ == '0));

  // enables and rounding mode only move on a write
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadAll |=> ($stable(enableQ) && $stable(rmQ)));
endmodule

// File: rtl/fpExcStatusReg.sv
module fpExcStatusReg
  import fpExcPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic                opStart,
  input  logic                excValid,
  input  logic [NUM_EXC-1:0]  excVec,
  output logic [RM_W-1:0]     roundMode,
  output logic                trapReq
);
  fpStrobeT            strobes;
  logic [NUM_EXC-1:0]  causeQ;
  logic [NUM_MASK-1:0] enableQ;
  logic [NUM_MASK-1:0] flagQ;
  logic [RM_W-1:0]     rmQ;
  logic                unusedWrHi;

  assign unusedWrHi = ^regWrData[REG_W-1:USED_W];

  fpExcControl uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .opStart(opStart),
    .excValid(excValid), .excVec(excVec), .causeQ(causeQ),
    .enableQ(enableQ), .strobes(strobes), .trapReq(trapReq)
  );

  fpExcDatapath uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrFields(regWrData[USED_W-1:0]), .excVec(excVec),
    .causeQ(causeQ), .enableQ(enableQ), .flagQ(flagQ), .rmQ(rmQ)
  );

  assign regRdData = {{(REG_W-USED_W){1'b0}}, causeQ, enableQ, flagQ, rmQ};
  assign roundMode = rmQ;

  // reserved bits never leak
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[REG_W-1:USED_W] == '0);

  // a lone write is read back on its low field
  assert_write_rm_R11: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (roundMode == $past(regWrData[RM_W-1:0])));
endmodule

// File: tb/fpExcStatusReg_bench.sv
`timescale 1ns/1ps
module fpExcStatusReg_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        opStart = 1'b0;
  logic        excValid = 1'b0;
  logic [5:0]  excVec = '0;
  logic [1:0]  roundMode;
  logic        trapReq;

  int total = 0;
  int bad = 0;
  string curReq = "R1";

  // reference state
  bit [5:0] mCause;
  bit [4:0] mEn;
  bit [4:0] mFlag;
  bit [1:0] mRm;

  always #2 clk = ~clk;

  fpExcStatusReg u_fpExcStatusReg (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .opStart(opStart), .excValid(excValid),
    .excVec(excVec), .roundMode(roundMode), .trapReq(trapReq)
  );

  function automatic bit [31:0] expWord();
    return {14'd0, mCause, mEn, mFlag, mRm};
  endfunction

  function automatic bit expTrap();
    bit t = mCause[5];
    for (int i = 0; i < 5; i++) if (mCause[i] && mEn[i]) t = 1'b1;
    return t;
  endfunction

  task automatic compareAll();
    total++;
    if (regRdData !== expWord()) begin
      bad++;
      $display("FAIL %s word actual=%h expected=%h", curReq, regRdData, expWord());
    end
    total++;
    if (trapReq !== expTrap()) begin
      bad++;
      $display("FAIL %s trap actual=%b expected=%b", curReq, trapReq, expTrap());
    end
    total++;
    if (roundMode !== mRm) begin
      bad++;
      $display("FAIL %s rm actual=%b expected=%b", curReq, roundMode, mRm);
    end
  endtask

  // one clock with the inputs currently applied, then compare mid-cycle
  task automatic tick();
    @(posedge clk);
    if (!rstN) begin
      mCause = '0; mEn = '0; mFlag = '0; mRm = '0;
    end else begin
      if (regWrEn) begin
        mCause = regWrData[17:12];
        mEn    = regWrData[11:7];
        mFlag  = regWrData[6:2];
        mRm    = regWrData[1:0];
      end
      if (opStart) mCause = '0;
      if (excValid) begin
        mCause = mCause | excVec;
        mFlag  = mFlag | excVec[4:0];
      end
    end
    @(negedge clk);
    compareAll();
    regWrEn = 1'b0; opStart = 1'b0; excValid = 1'b0; excVec = '0;
  endtask

  task automatic doWrite(input bit [31:0] d);
    regWrEn = 1'b1; regWrData = d; tick();
  endtask
  task automatic doStart();
    opStart = 1'b1; tick();
  endtask
  task automatic doEvent(input bit [5:0] v);
    excValid = 1'b1; excVec = v; tick();
  endtask

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    curReq = "R1";
    tick(); tick();
    rstN = 1'b1;
    tick();

    curReq = "R2";
    doWrite(32'hFFFF_FFFF);
    tick();
    curReq = "R3";
    doWrite(32'h0000_0000);
    doWrite({14'd0, 6'b010101, 5'b10100, 5'b01011, 2'b01});

    curReq = "R11";
    doWrite({14'd0, 6'd0, 5'd0, 5'd0, 2'b10});
    doWrite({14'd0, 6'd0, 5'd0, 5'd0, 2'b11});

    curReq = "R4";
    doWrite({14'h3FFF, 6'b111111, 5'b00011, 5'b10101, 2'b00});
    doStart();
    tick();

    curReq = "R5";
    doEvent(6'b000001);
    doEvent(6'b010000);
    doStart();
    curReq = "R8";
    doWrite(32'h0);
    doEvent(6'b100000);
    doStart();
    curReq = "R7";
    doWrite({14'd0, 6'd0, 5'b00100, 5'd0, 2'b01});
    doEvent(6'b001000);   // Z not enabled
    doStart();
    doEvent(6'b000100);   // O enabled
    doStart();

    curReq = "R6";
    doEvent(6'b011111);
    doStart();
    doStart();
    doEvent(6'b000010);
    tick();

    curReq = "R9";
    regWrEn = 1'b1; regWrData = 32'h0;
    excValid = 1'b1; excVec = 6'b101010;
    tick();
    tick();

    curReq = "R10";
    opStart = 1'b1; excValid = 1'b1; excVec = 6'b000011;
    tick();
    regWrEn = 1'b1; regWrData = {14'd0, 6'b111100, 5'd0, 5'd0, 2'b00};
    opStart = 1'b1;
    tick();

    curReq = "R5";
    for (int i = 0; i < 400; i++) begin
      regWrEn  = ($urandom_range(0, 7) == 0);
      regWrData = $urandom();
      opStart  = ($urandom_range(0, 3) == 0);
      excValid = ($urandom_range(0, 2) == 0);
      excVec   = 6'($urandom());
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule